// File: doc/BRIEF.md
# Smart-Card Character Receiver

This block recovers characters from the single half-duplex I/O line of a smart-card interface. A sample strobe at five times the elementary time unit (etu) rate paces all timing. A single bit lasts five strobes. The line is asynchronous to the block clock, so it first passes through a short synchroniser. The receiver then watches for a falling start bit, takes eight data bits and one parity bit at their centres, and checks that the line is high where the stop level should be.

A good character appears as an 8-bit byte with a single-cycle valid pulse. A parity flag accompanies each delivered byte. A low stop level (a framing error or a break) delivers nothing and sets a sticky flag that only the clear input removes. In that case the receiver does not look for a new start bit until the line has gone high again. After a good stop level it is ready for the next start bit immediately, so a transmitter that runs slightly fast is still received.

Top module: `sc_char_rx`

## Requirements
- R1: After reset, `valid_o`, `data_o`, `parity_err_o` and `frame_err_o` are all 0. The synchronised line starts at the idle (high) level.
- R2: The line is looked at only in cycles where `tick_i` is 1. In the idle state, a low level seen on such a tick marks the start bit, and that tick is called tick 0.
- R3: Bits are sampled on ticks 8, 13, 18, … 48 (every 5 ticks after tick 8). That gives 9 bits in total. The first 8 are data, least significant bit first, and the ninth is parity.
- R4: The stop level is checked on tick 53. If it is high, `data_o` holds the byte and `valid_o` is 1 for exactly the one clock cycle that follows that tick edge.
- R5: Parity is even across the 8 data bits plus the parity bit. `parity_err_o` is 1 together with `valid_o` when the count of ones is odd, and 0 at all other times. The byte is still delivered when parity is wrong.
- R6: If the stop level on tick 53 is low, no valid pulse is produced and `frame_err_o` becomes 1. It stays 1 until it is cleared.
- R7: After a framing error, the receiver starts no new character until it has seen the line high on a tick.
- R8: A cycle with `err_clr_i` = 1 clears `frame_err_o`. If a new framing error lands in the same cycle, the flag stays set.
- R9: After a good stop level the receiver rearms at once. A start bit seen on tick 54 is received correctly.
- R10: The line passes through a two-flop synchroniser. A low pulse of one clock that falls between two ticks starts no character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Sample strobe at 5x the etu rate, one clock wide |
| line_i | input | 1 | Card I/O line, asynchronous |
| err_clr_i | input | 1 | Clears the sticky framing flag |
| data_o | output | 8 | Received byte, least significant bit first on the line |
| valid_o | output | 1 | One-cycle strobe for a delivered byte |
| parity_err_o | output | 1 | Even-parity mismatch for the byte on `data_o` |
| frame_err_o | output | 1 | Sticky framing/break flag |

## Verification
If the tick counter is off by even one tick, the valid pulse arrives at the wrong tick. A sample may also land in a neighbouring bit, so a byte with alternating bit patterns comes out shifted. The scoreboard records the tick number at which each byte is due, so a wrong count shows up on the very first character. If the state is wrong after a framing error, the receiver rearms while the line is still low. The character that follows then comes out misframed or garbled, within one character time of the line going high. A parity or flag inversion shows on the next delivered byte, or on the next framing event.

// File: rtl/sc_rx_pkg.sv
package sc_rx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_BITS,
    ST_STOP,
    ST_WAIT_HI
  } rx_state_e;
endpackage

// File: rtl/sc_rx_sync.sv
module sc_rx_sync #(
  parameter int unsigned STAGES = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[g] <= RST_VAL;
      else if (g == 0) chain_q[g] <= d_i;
      else chain_q[g] <= chain_q[(g == 0) ? 0 : g-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/sc_rx_frame.sv
module sc_rx_frame
  import sc_rx_pkg::*;
#(
  parameter int unsigned OSR       = 5,
  parameter int unsigned FIRST_OFS = 8,
  parameter int unsigned NBITS     = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             line_i,
  output logic [NBITS-1:0] char_o,
  output logic             done_o,
  output logic             ferr_o
);
  localparam int unsigned CNT_MAX = (FIRST_OFS > OSR) ? FIRST_OFS : OSR;
  localparam int unsigned CW      = $clog2(CNT_MAX + 1);
  localparam int unsigned BW      = $clog2(NBITS + 1);

  rx_state_e        state_q;
  logic [CW-1:0]    cnt_q;
  logic [BW-1:0]    bitn_q;
  logic [NBITS-1:0] shreg_q;
  logic             stop_pt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      bitn_q  <= '0;
      shreg_q <= '0;
    end else if (tick_i) begin
      unique case (state_q)
        ST_IDLE: if (!line_i) begin
          state_q <= ST_BITS;
          cnt_q   <= CW'(FIRST_OFS - 1);
          bitn_q  <= '0;
        end
        ST_BITS: if (cnt_q == '0) begin
          shreg_q <= {line_i, shreg_q[NBITS-1:1]};  // LSB first
          cnt_q   <= CW'(OSR - 1);
          if (bitn_q == BW'(NBITS - 1)) state_q <= ST_STOP;
          else bitn_q <= bitn_q + 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
        ST_STOP: if (cnt_q == '0) begin
          state_q <= line_i ? ST_IDLE : ST_WAIT_HI;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
        ST_WAIT_HI: if (line_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign stop_pt = tick_i && (state_q == ST_STOP) && (cnt_q == '0);
  assign done_o  = stop_pt && line_i;
  assign ferr_o  = stop_pt && !line_i;
  assign char_o  = shreg_q;
endmodule

// File: rtl/sc_rx_flags.sv
module sc_rx_flags #(
  parameter int unsigned DATA_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [DATA_W:0] char_i,
  input  logic            done_i,
  input  logic            ferr_i,
  input  logic            clr_i,
  output logic [DATA_W-1:0] data_o,
  output logic            valid_o,
  output logic            perr_o,
  output logic            ferr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o  <= '0;
      valid_o <= 1'b0;
      perr_o  <= 1'b0;
      ferr_o  <= 1'b0;
    end else begin
      valid_o <= done_i;
      perr_o  <= done_i && (^char_i);
      if (done_i) data_o <= char_i[DATA_W-1:0];
      // new error wins over clear
      if (ferr_i) ferr_o <= 1'b1;
      else if (clr_i) ferr_o <= 1'b0;
    end
  end
endmodule

// File: rtl/sc_char_rx.sv
module sc_char_rx #(
  parameter int unsigned OSR         = 5,
  parameter int unsigned FIRST_OFS   = 8,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              line_i,
  input  logic              err_clr_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              parity_err_o,
  output logic              frame_err_o
);
  localparam int unsigned NBITS = DATA_W + 1;

  logic             line_s;
  logic [NBITS-1:0] char_w;
  logic             done_w;
  logic             ferr_w;

  sc_rx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (line_i),
    .q_o   (line_s)
  );

  sc_rx_frame #(.OSR(OSR), .FIRST_OFS(FIRST_OFS), .NBITS(NBITS)) u_frame (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick_i),
    .line_i(line_s),
    .char_o(char_w),
    .done_o(done_w),
    .ferr_o(ferr_w)
  );

  sc_rx_flags #(.DATA_W(DATA_W)) u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .char_i (char_w),
    .done_i (done_w),
    .ferr_i (ferr_w),
    .clr_i  (err_clr_i),
    .data_o (data_o),
    .valid_o(valid_o),
    .perr_o (parity_err_o),
    .ferr_o (frame_err_o)
  );
endmodule

// File: rtl/sc_char_rx_chk.sv
module sc_char_rx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tick_i,
  input logic err_clr_i,
  input logic valid_o,
  input logic parity_err_o,
  input logic frame_err_o
);
  // R4
  valid_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  // R2
  valid_after_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(tick_i));

  // R5
  perr_with_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    parity_err_o |-> valid_o);

  // R6
  ferr_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_err_o && !err_clr_i) |=> frame_err_o);

  // R6
  ferr_no_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(frame_err_o) |-> (!valid_o && $past(tick_i)));

  // R8
  ferr_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_clr_i && !tick_i) |=> !frame_err_o);
endmodule

bind sc_char_rx sc_char_rx_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tick_i      (tick_i),
  .err_clr_i   (err_clr_i),
  .valid_o     (valid_o),
  .parity_err_o(parity_err_o),
  .frame_err_o (frame_err_o)
);

// File: tb/sc_char_rx_tb.sv
module sc_char_rx_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       line_i = 1'b1;
  logic       err_clr_i = 1'b0;
  logic [7:0] data_o;
  logic       valid_o;
  logic       parity_err_o;
  logic       frame_err_o;

  int n_chk = 0;
  int n_err = 0;
  int tick_n = 0;
  int n_valid = 0;

  logic [7:0] q_data[$];
  bit         q_perr[$];
  int         q_tick[$];

  sc_char_rx u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .line_i(line_i),
    .err_clr_i(err_clr_i), .data_o(data_o), .valid_o(valid_o),
    .parity_err_o(parity_err_o), .frame_err_o(frame_err_o)
  );

  always #10 clk_i = ~clk_i;  // 50 MHz

  always @(posedge clk_i) if (tick_i) tick_n <= tick_n + 1;

  initial begin
    int div = 0;
    forever begin
      @(negedge clk_i);
      div = (div + 1) % 4;
      tick_i = (div == 0);
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk_i);
      if (valid_o) begin
        n_valid++;
        if (q_data.size() == 0) begin
          chk(0, "R6", "unexpected valid", 1, 0);
        end else begin
          logic [7:0] ed;
          bit ep;
          int et;
          ed = q_data.pop_front();
          ep = q_perr.pop_front();
          et = q_tick.pop_front();
          chk(data_o == ed, "R3", "data", data_o, ed);
          chk(parity_err_o == ep, "R5", "parity flag", parity_err_o, ep);
          chk(tick_n == et, "R4", "delivery tick", tick_n, et);
        end
      end
    end
  end

  task automatic drive_tick(logic v);
    @(posedge clk_i);
    while (!tick_i) @(posedge clk_i);
    #1 line_i = v;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) drive_tick(1'b1);
  endtask

  // frame: stop level held low; clr_at_stop raises clear across the stop check
  task automatic send_char(logic [7:0] d, bit bad_par, int stop_len, bit frame, bit clr_at_stop);
    int k0;
    logic par;
    par = (^d) ^ bad_par;
    drive_tick(1'b0);
    k0 = tick_n;
    if (!frame) begin
      q_data.push_back(d);
      q_perr.push_back(bad_par);
      q_tick.push_back(k0 + 54);
    end
    for (int i = 0; i < 4; i++) drive_tick(1'b0);
    for (int b = 0; b < 8; b++)
      for (int i = 0; i < 5; i++) drive_tick(d[b]);
    for (int i = 0; i < 5; i++) drive_tick(par);
    if (!frame) begin
      for (int i = 0; i < stop_len; i++) drive_tick(1'b1);
    end else begin
      for (int i = 0; i < 5; i++) begin
        drive_tick(1'b0);
        if (clr_at_stop && i == 3) err_clr_i = 1'b1;
        if (clr_at_stop && i == 4) err_clr_i = 1'b0;
      end
    end
  endtask

  initial begin
    #4_000_000;
    chk(0, "R1", "watchdog expired", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int v0;
    repeat (5) @(negedge clk_i);
    // R1
    chk(valid_o == 0 && data_o == 0 && parity_err_o == 0 && frame_err_o == 0,
        "R1", "reset outputs", {valid_o, parity_err_o, frame_err_o}, 0);
    rst_ni = 1'b1;
    idle(3);

    // R2 R3 R4: single good characters
    send_char(8'hA5, 0, 5, 0, 0);
    idle(2);
    chk(n_valid == 1, "R2", "start detected once", n_valid, 1);
    send_char(8'h3C, 0, 5, 0, 0);
    idle(1);
    send_char(8'h01, 1, 5, 0, 0);  // R5 bad parity
    idle(3);
    send_char(8'h80, 0, 5, 0, 0);
    send_char(8'hFF, 1, 5, 0, 0);
    send_char(8'h00, 0, 5, 0, 0);
    idle(2);

    // R9: stop shortened to 4 ticks, next start on tick 54
    v0 = n_valid;
    send_char(8'h5A, 0, 4, 0, 0);
    send_char(8'hC3, 0, 5, 0, 0);
    idle(2);
    chk(n_valid == v0 + 2, "R9", "back-to-back count", n_valid - v0, 2);

    // R10: one-clock glitch between ticks
    v0 = n_valid;
    drive_tick(1'b1);
    line_i = 1'b0;
    @(posedge clk_i);
    #1 line_i = 1'b1;
    idle(60);
    chk(n_valid == v0 && frame_err_o == 0, "R10", "glitch ignored",
        {n_valid - v0, frame_err_o}, 0);

    // R6 R8: framing error with clear in the same cycle, set wins
    send_char(8'h77, 0, 0, 1, 1);
    for (int i = 0; i < 10; i++) drive_tick(1'b0);
    @(negedge clk_i);
    chk(frame_err_o == 1, "R8", "set wins over clear", frame_err_o, 1);

    // R7: rearm only after line returns high
    v0 = n_valid;
    idle(2);
    send_char(8'h4E, 0, 5, 0, 0);
    idle(2);
    chk(n_valid == v0 + 1, "R7", "char after error", n_valid - v0, 1);
    @(negedge clk_i);
    chk(frame_err_o == 1, "R6", "flag sticky", frame_err_o, 1);

    // R8: clear
    err_clr_i = 1'b1;
    @(negedge clk_i);
    err_clr_i = 1'b0;
    @(negedge clk_i);
    chk(frame_err_o == 0, "R8", "clear", frame_err_o, 0);

    // R6: break (line held low)
    v0 = n_valid;
    for (int i = 0; i < 80; i++) drive_tick(1'b0);
    @(negedge clk_i);
    chk(frame_err_o == 1 && n_valid == v0, "R6", "break flagged",
        {frame_err_o, n_valid - v0}, 2);
    idle(3);
    send_char(8'h99, 0, 5, 0, 0);
    idle(60);

    chk(q_data.size() == 0, "R4", "pending expected bytes", q_data.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule